// File: doc/BRIEF.md
# CAN Controller Status and Interrupt Identifier

This block holds the control, status and error-counter views of a CAN controller, and it turns controller events into a single interrupt line. The protocol engine reports several things to it: successful transmissions and receptions, a last-error code, its error-state flags, its error counters, and a vector of per-object interrupt-pending bits. The block records these events in the status register. It raises a status interrupt when a relevant change occurs. It also presents an identifier that tells the CPU which source to service first.

A status interrupt always outranks message objects and reads as the fixed code 0x8000. When no status interrupt is pending, the identifier gives the lowest-numbered message object with a pending interrupt, or 0 when nothing is pending. Software can detect a fresh bus event by writing the value 7 into the error-code field. Any later error event from the engine overwrites that value, so a 7 that stays in place means no bus event has occurred.

Top module: `can_stat_irq`

## Requirements
- R1: While reset is held, the control register reads 0x01, the status register and the error-count view read 0, the identifier reads 0 and the interrupt line is low.
- R2: A CPU control write stores data bits 7, 3, 2, 1 and 0 (test, error enable, status-change enable, interrupt enable, init). Control bits 6:4 always read 0.
- R3: Status bit 4 (receive OK) and bit 3 (transmit OK) are set by their engine event pulse. A CPU status write clears a bit where the data holds 0 and leaves it unchanged where the data holds 1. An event in the same cycle as a clear wins.
- R4: Status bits 2:0 hold the last error code: 0 none, 1 stuff, 2 form, 3 acknowledge, 4 bit-1, 5 bit-0, 6 CRC, 7 unused. An engine error event loads its code. Otherwise a CPU status write loads data bits 2:0.
- R5: Status bits 7, 6 and 5 show the bus-off, warning and passive inputs of the previous cycle. CPU writes do not change them.
- R6: With control bit 2 set, a status interrupt becomes pending on a receive-OK or transmit-OK event. It also becomes pending on an error event whose code is not 7 while the stored code is 7. An error event that arrives while the stored code is not 7 raises nothing.
- R7: With control bit 3 set, a status interrupt becomes pending when any of the three error-state inputs differs from its stored status bit. With control bit 3 clear, such a change raises nothing.
- R8: A status-read strobe clears the pending status interrupt, unless a new cause arrives in the same cycle.
- R9: While a status interrupt is pending, the identifier reads 0x8000, whatever the object bits are.
- R10: Otherwise, pending bit i gives object number i+1, and the identifier reads the lowest such number. It reads 0 when no bit is set.
- R11: The interrupt line is high when control bit 1 is set and either a status interrupt is pending or any object bit is set.
- R12: The error-count view reads {receive-passive, receive count[6:0], transmit count[7:0]} as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_sel_stat | input | 1 | Write target: 0 control, 1 status |
| cpu_wdata | input | 8 | CPU write data |
| cpu_stat_rd | input | 1 | Status register read strobe |
| ev_txok | input | 1 | Engine: frame transmitted |
| ev_rxok | input | 1 | Engine: frame received |
| ev_lec_vld | input | 1 | Engine: error code valid |
| ev_lec | input | 3 | Engine: error code |
| st_bus_off | input | 1 | Engine: bus-off state |
| st_warn | input | 1 | Engine: warning state |
| st_passive | input | 1 | Engine: passive state |
| tec_in | input | 8 | Transmit error count |
| rec_in | input | 7 | Receive error count |
| rec_passive_in | input | 1 | Receive-passive flag |
| obj_pend | input | 32 | Per-object interrupt pending |
| ctrl_q | output | 8 | Control register |
| stat_q | output | 8 | Status register |
| errcnt_q | output | 16 | Error-count view |
| int_id | output | 16 | Interrupt identifier |
| irq | output | 1 | Interrupt line |

## Verification
The hardest case to reach is the error-code condition that depends on history. An error event raises an interrupt only when the CPU has written 7 beforehand and no other event has overwritten it since. Random traffic alone seldom produces this sequence. The bench therefore drives directed sequences: it writes 7, sends an error event, clears the pending interrupt with a read, and then sends a second error event that must stay silent. A read is also placed in the same cycle as a new cause. Random cycles then mix CPU writes, reads and sparse events, and they are compared against a cycle model kept in the bench.

// File: rtl/can_stat_irq_pkg.sv
package can_stat_irq_pkg;
   localparam logic [2:0] LEC_NONE   = 3'd0;
   localparam logic [2:0] LEC_UNUSED = 3'd7;
   localparam logic [7:0] CTRL_WMASK = 8'h8F;
   localparam logic [7:0] CTRL_RESET = 8'h01;
   localparam int CB_INIT = 0;
   localparam int CB_IE   = 1;
   localparam int CB_SIE  = 2;
   localparam int CB_EIE  = 3;
   localparam int CB_TEST = 7;

   typedef struct packed {
      logic       bus_off;
      logic       warn;
      logic       passive;
      logic       rxok;
      logic       txok;
      logic [2:0] lec;
   } stat_t;
endpackage

// File: rtl/can_si_ctrl.sv
module can_si_ctrl
   import can_stat_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   output logic [7:0] ctrl_q,
   output logic       ie,
   output logic       sie,
   output logic       eie
);
   always_ff @(posedge clk) begin
      if (!rst_n)     ctrl_q <= CTRL_RESET;
      else if (wr_en) ctrl_q <= wdata & CTRL_WMASK;
   end

   assign ie  = ctrl_q[CB_IE];
   assign sie = ctrl_q[CB_SIE];
   assign eie = ctrl_q[CB_EIE];

   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctrl_q[6:4] == 3'b000)); // R2
endmodule

// File: rtl/can_si_status.sv
module can_si_status
   import can_stat_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [4:0] wdata,
   input  logic       rd_stb,
   input  logic       sie,
   input  logic       eie,
   input  logic       ev_txok,
   input  logic       ev_rxok,
   input  logic       ev_lec_vld,
   input  logic [2:0] ev_lec,
   input  logic [2:0] st_in,
   output stat_t      stat_q,
   output logic       pend_q
);
   logic [2:0] st_old;
   logic       lec_fresh;
   logic       st_change;
   logic       pend_set;

   assign st_old    = {stat_q.bus_off, stat_q.warn, stat_q.passive};
   assign lec_fresh = ev_lec_vld && (stat_q.lec == LEC_UNUSED) && (ev_lec != LEC_UNUSED);
   assign st_change = (st_in != st_old);
   assign pend_set  = (sie && (ev_rxok || ev_txok || lec_fresh)) || (eie && st_change);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         pend_q <= 1'b0;
      end else begin
         {stat_q.bus_off, stat_q.warn, stat_q.passive} <= st_in;
         stat_q.rxok <= (stat_q.rxok && !(wr_en && !wdata[4])) || ev_rxok;
         stat_q.txok <= (stat_q.txok && !(wr_en && !wdata[3])) || ev_txok;
         if (ev_lec_vld)  stat_q.lec <= ev_lec;
         else if (wr_en)  stat_q.lec <= wdata[2:0];
         pend_q <= pend_set || (pend_q && !rd_stb);
      end
   end

   AST_RXOK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rxok |=> stat_q.rxok); // R3
   AST_LEC_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_lec_vld |=> (stat_q.lec == $past(ev_lec))); // R4
   AST_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sie && !eie) |=> !$rose(pend_q)); // R6
endmodule

// File: rtl/can_si_obj_prio.sv
module can_si_obj_prio #(
   parameter int NUM_OBJ   = 32,
   parameter int ID_W      = 16,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_OBJ-1:0] pend,
   output logic [ID_W-1:0]    obj_id
);
   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            obj_id = '0;
            for (int i = NUM_OBJ - 1; i >= 0; i--)
               if (pend[i]) obj_id = ID_W'(i + 1);
         end
      end else begin : g_high
         always_comb begin
            obj_id = '0;
            for (int i = 0; i < NUM_OBJ; i++)
               if (pend[i]) obj_id = ID_W'(i + 1);
         end
      end
   endgenerate

   AST_ID_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (obj_id != '0) |-> pend[obj_id - 1'b1]); // R10
   AST_ID_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (obj_id == '0) |-> (pend == '0)); // R10
endmodule

// File: rtl/can_stat_irq.sv
module can_stat_irq
   import can_stat_irq_pkg::*;
#(
   parameter int NUM_OBJ   = 32,
   parameter int ID_W      = 16,
   parameter int TEC_W     = 8,
   parameter int REC_W     = 7,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cpu_wr,
   input  logic                     cpu_sel_stat,
   input  logic [7:0]               cpu_wdata,
   input  logic                     cpu_stat_rd,
   input  logic                     ev_txok,
   input  logic                     ev_rxok,
   input  logic                     ev_lec_vld,
   input  logic [2:0]               ev_lec,
   input  logic                     st_bus_off,
   input  logic                     st_warn,
   input  logic                     st_passive,
   input  logic [TEC_W-1:0]         tec_in,
   input  logic [REC_W-1:0]         rec_in,
   input  logic                     rec_passive_in,
   input  logic [NUM_OBJ-1:0]       obj_pend,
   output logic [7:0]               ctrl_q,
   output logic [7:0]               stat_q,
   output logic [TEC_W+REC_W:0]     errcnt_q,
   output logic [ID_W-1:0]          int_id,
   output logic                     irq
);
   localparam int ERR_W = TEC_W + REC_W + 1;
   localparam logic [ID_W-1:0] STAT_CODE = {1'b1, {(ID_W-1){1'b0}}};

   generate
      if (NUM_OBJ < 1 || NUM_OBJ >= (1 << (ID_W - 1))) begin : g_bad_obj
         $error("NUM_OBJ must fit below the status code");
      end
      if (ID_W < 2) begin : g_bad_idw
         $error("ID_W too small");
      end
   endgenerate

   logic       ie, sie, eie;
   logic       pend_q;
   stat_t      stat_s;
   logic [ID_W-1:0] obj_id;

   can_si_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cpu_wr && !cpu_sel_stat), .wdata(cpu_wdata),
      .ctrl_q(ctrl_q), .ie(ie), .sie(sie), .eie(eie)
   );

   can_si_status u_stat (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cpu_wr && cpu_sel_stat), .wdata(cpu_wdata[4:0]),
      .rd_stb(cpu_stat_rd), .sie(sie), .eie(eie),
      .ev_txok(ev_txok), .ev_rxok(ev_rxok),
      .ev_lec_vld(ev_lec_vld), .ev_lec(ev_lec),
      .st_in({st_bus_off, st_warn, st_passive}),
      .stat_q(stat_s), .pend_q(pend_q)
   );

   can_si_obj_prio #(.NUM_OBJ(NUM_OBJ), .ID_W(ID_W), .LOW_FIRST(LOW_FIRST)) u_prio (
      .clk(clk), .rst_n(rst_n), .pend(obj_pend), .obj_id(obj_id)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) errcnt_q <= '0;
      else        errcnt_q <= {rec_passive_in, rec_in, tec_in};
   end

   assign stat_q = stat_s;
   assign int_id = pend_q ? STAT_CODE : obj_id;
   assign irq    = ie && (pend_q || (obj_pend != '0));

   AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (int_id == STAT_CODE)); // R9
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[CB_IE] |-> !irq); // R11
   AST_ERRCNT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (errcnt_q[ERR_W-1] == $past(rec_passive_in))); // R12
endmodule

// File: tb/can_stat_irq_tb_top.sv
module can_stat_irq_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        cpu_wr, cpu_sel_stat, cpu_stat_rd;
   logic [7:0]  cpu_wdata;
   logic        ev_txok, ev_rxok, ev_lec_vld;
   logic [2:0]  ev_lec;
   logic        st_bus_off, st_warn, st_passive;
   logic [7:0]  tec_in;
   logic [6:0]  rec_in;
   logic        rec_passive_in;
   logic [31:0] obj_pend;
   logic [7:0]  ctrl_q, stat_q;
   logic [15:0] errcnt_q, int_id;
   logic        irq;

   can_stat_irq dut_i (.*);

   int n_chk = 0, n_fail = 0;
   logic [7:0]  m_ctrl, m_stat;
   logic [15:0] m_err;
   logic        m_pend;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] exp_id(input logic p, input logic [31:0] o);
      exp_id = 16'h0;
      if (p) return 16'h8000;
      for (int i = 31; i >= 0; i--) if (o[i]) exp_id = 16'(i + 1);
   endfunction

   task automatic model_update();
      logic wr_s, set;
      wr_s = cpu_wr && cpu_sel_stat;
      set = (m_ctrl[2] && (ev_rxok || ev_txok ||
             (ev_lec_vld && m_stat[2:0] == 3'd7 && ev_lec != 3'd7))) ||
            (m_ctrl[3] && ({st_bus_off, st_warn, st_passive} != m_stat[7:5]));
      m_pend = set || (m_pend && !cpu_stat_rd);
      m_stat[4] = (m_stat[4] && !(wr_s && !cpu_wdata[4])) || ev_rxok;
      m_stat[3] = (m_stat[3] && !(wr_s && !cpu_wdata[3])) || ev_txok;
      if (ev_lec_vld) m_stat[2:0] = ev_lec;
      else if (wr_s)  m_stat[2:0] = cpu_wdata[2:0];
      m_stat[7:5] = {st_bus_off, st_warn, st_passive};
      if (cpu_wr && !cpu_sel_stat) m_ctrl = cpu_wdata & 8'h8F;
      m_err = {rec_passive_in, rec_in, tec_in};
   endtask

   task automatic check_all();
      chk("R2 ctrl", ctrl_q, m_ctrl);
      chk("R3 ok bits", stat_q[4:3], m_stat[4:3]);
      chk("R4 lec", stat_q[2:0], m_stat[2:0]);
      chk("R5 state bits", stat_q[7:5], m_stat[7:5]);
      chk("R12 errcnt", errcnt_q, m_err);
      chk(m_pend ? "R9 id" : "R10 id", int_id, exp_id(m_pend, obj_pend));
      chk("R11 irq", irq, m_ctrl[1] && (m_pend || obj_pend != 0));
   endtask

   task automatic cyc();
      @(posedge clk);
      model_update();
      #1 check_all();
      @(negedge clk);
   endtask

   task automatic idle();
      cpu_wr = 0; cpu_sel_stat = 0; cpu_wdata = 0; cpu_stat_rd = 0;
      ev_txok = 0; ev_rxok = 0; ev_lec_vld = 0; ev_lec = 0;
   endtask

   initial begin
      #(4 * 150000);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h1234_5678));
      idle();
      st_bus_off = 0; st_warn = 0; st_passive = 0;
      tec_in = 0; rec_in = 0; rec_passive_in = 0; obj_pend = 0;
      repeat (3) @(negedge clk);
      chk("R1 ctrl reset", ctrl_q, 8'h01);
      chk("R1 stat reset", stat_q, 8'h00);
      chk("R1 errcnt reset", errcnt_q, 16'h0);
      chk("R1 id reset", int_id, 16'h0);
      chk("R1 irq reset", irq, 1'b0);
      m_ctrl = 8'h01; m_stat = 0; m_err = 0; m_pend = 0;
      rst_n = 1;

      // R2 reserved bits and R6 receive-OK event
      cpu_wr = 1; cpu_wdata = 8'hF7; cyc(); idle();
      chk("R2 reserved zero", ctrl_q, 8'h87);
      ev_rxok = 1; cyc(); idle();
      chk("R6 rxok raises", int_id, 16'h8000);
      // R8 read with concurrent cause keeps pending, then plain read clears
      cpu_stat_rd = 1; ev_txok = 1; cyc(); idle();
      chk("R8 read plus cause", int_id, 16'h8000);
      cpu_stat_rd = 1; cyc(); idle();
      chk("R8 read clears", int_id, 16'h0);
      // R3 write 1 keeps, write 0 clears
      cpu_wr = 1; cpu_sel_stat = 1; cpu_wdata = 8'h1F; cyc(); idle();
      chk("R3 write ones keep", stat_q[4:3], 2'b11);
      // R6 fresh error code after sentinel
      ev_lec_vld = 1; ev_lec = 3'd3; cyc(); idle();
      chk("R6 fresh lec", int_id, 16'h8000);
      cpu_stat_rd = 1; cyc(); idle();
      ev_lec_vld = 1; ev_lec = 3'd5; cyc(); idle();
      chk("R6 stale lec silent", int_id, 16'h0);
      cpu_wr = 1; cpu_sel_stat = 1; cpu_wdata = 8'h02; ev_lec_vld = 1; ev_lec = 3'd6; cyc(); idle();
      chk("R3 clear bits", stat_q[4:3], 2'b00);
      chk("R4 event beats write", stat_q[2:0], 3'd6);
      // R7 state change with and without EIE
      cpu_wr = 1; cpu_wdata = 8'h03; cyc(); idle();
      st_warn = 1; cyc();
      chk("R7 no eie silent", int_id, 16'h0);
      cpu_wr = 1; cpu_wdata = 8'h0B; cyc(); idle();
      st_warn = 0; cyc();
      chk("R7 eie raises", int_id, 16'h8000);
      cpu_stat_rd = 1; cyc(); idle();
      // R10 lowest object
      obj_pend = 32'h8000_0010; cyc();
      chk("R10 lowest", int_id, 16'd5);
      obj_pend = 32'h8000_0000; cyc();
      chk("R10 top object", int_id, 16'd32);
      obj_pend = 0;

      for (int k = 0; k < 3000; k++) begin
         cpu_wr = ($urandom % 6) == 0;
         cpu_sel_stat = $urandom % 2;
         cpu_wdata = 8'($urandom);
         if (cpu_wr && !cpu_sel_stat && ($urandom % 2)) cpu_wdata[3:1] = 3'b111;
         cpu_stat_rd = ($urandom % 5) == 0;
         ev_txok = ($urandom % 9) == 0;
         ev_rxok = ($urandom % 9) == 0;
         ev_lec_vld = ($urandom % 7) == 0;
         ev_lec = 3'($urandom);
         if (($urandom % 20) == 0) {st_bus_off, st_warn, st_passive} = 3'($urandom);
         tec_in = 8'($urandom); rec_in = 7'($urandom); rec_passive_in = 1'($urandom);
         obj_pend = $urandom & $urandom & $urandom;
         cyc();
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule